// File: doc/BRIEF.md
# Random Number Generator Register Front End

This block is the host-facing register file of a true random number generator. A host on a simple bus (address, write strobe, write data, read strobe, read data) sees three 32-bit registers inside a 1 KiB window: a control word, a status word and a read-only data word. The entropy core behind it delivers 32-bit random words with a valid strobe and reports live clock and seed faults. The block hands back to the core an enable and a clock-check enable.

Each delivered word is held in a one-word buffer and flagged ready until the host reads the data offset. The clock and seed faults appear as live status bits and also latch into sticky flags. Software clears a sticky flag by writing 0 to its bit. A single interrupt line combines the ready flag and both sticky flags, gated by an interrupt-enable bit.

Top module: `rng_regfile`

## Requirements
- R1: After reset the control, status and data offsets all read 0, and `irq`, `core_en` and `core_ced_en` are 0.
- R2: Control offset 0x0 holds the generator enable at bit 2, the interrupt enable at bit 3 and the clock-check disable at bit 5 (1 = checking off). All other bits read 0. `core_en` equals bit 2, and `core_ced_en` is bit 2 AND NOT bit 5.
- R3: A control write changes bit 5 only if bit 2 was 0 before that write. Otherwise bit 5 keeps its value, while bits 2 and 3 still take the written values.
- R4: A `core_valid` pulse stores `core_word` in the buffer. In the next cycle the buffer reads at offset 0x8 and status bit 0 (ready) is 1. Words are accepted whether or not the generator is enabled.
- R5: A read strobe at offset 0x8 clears ready in the next cycle. If `core_valid` arrives in the same cycle, the new word is loaded and ready stays 1.
- R6: Status bit 1 reflects `core_clk_err` and status bit 2 reflects `core_seed_err`, each one cycle later. The clock fault is masked to 0 while control bit 5 is 1.
- R7: Status bit 5 (sticky clock fault) and bit 6 (sticky seed fault) are set in the same cycle as their live bits. A status write with that bit 0 clears it, and a write with that bit 1 leaves it unchanged. A live fault in the same cycle as a clearing write keeps the flag set.
- R8: Bus writes to status bits 0 to 2 and to the data offset have no effect.
- R9: `irq` is 1 exactly when interrupt enable is 1 and at least one of ready, sticky clock fault or sticky seed fault is 1.
- R10: Reads of any offset other than 0x0, 0x4 and 0x8 in the window return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe (side effect only at the data offset) |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| core_word | input | DATA_W | Random word from the entropy core |
| core_valid | input | 1 | `core_word` is valid this cycle |
| core_clk_err | input | 1 | Live clock fault from the core |
| core_seed_err | input | 1 | Live seed fault from the core |
| core_en | output | 1 | Generator enable to the core |
| core_ced_en | output | 1 | Clock-check enable to the core |
| irq | output | 1 | Interrupt request |

## Verification
The bench covers these corner cases:
- A write to the clock-check bit while the generator is running. A design that does not lock the bit would drop clock checking on a live generator.
- A data read that coincides with a new word. A design that gives the read priority would lose the ready flag on a word that was never read.
- A status write of all ones. A design that wrote ones through would raise errors by itself or fake a ready flag.
- A clearing write in the same cycle as a fresh fault. A design that gives the clear priority would silently drop that fault.
- A clock fault while checking is off, and a word that arrives while the generator is disabled. Each shows whether masking and buffering follow the control bits.

// File: rtl/rng_regfile.sv
module rng_regfile #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] core_word,
  input  logic              core_valid,
  input  logic              core_clk_err,
  input  logic              core_seed_err,
  output logic              core_en,
  output logic              core_ced_en,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(8);
  localparam int B_EN   = 2;
  localparam int B_IE   = 3;
  localparam int B_CED  = 5;
  localparam int B_RDY  = 0;
  localparam int B_CLKL = 1;
  localparam int B_SEDL = 2;
  localparam int B_CLKS = 5;
  localparam int B_SEDS = 6;

  logic              gen_en, int_en, ced_off;
  logic              ready, clk_live, seed_live, clk_stky, seed_stky;
  logic [DATA_W-1:0] buf_q;

  logic wr_ctrl, wr_stat, rd_data, clk_err_now;
  assign wr_ctrl     = bus_wr && (bus_addr == OFF_CTRL);
  assign wr_stat     = bus_wr && (bus_addr == OFF_STAT);
  assign rd_data     = bus_rd && (bus_addr == OFF_DATA);
  assign clk_err_now = core_clk_err && !ced_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gen_en  <= 1'b0;
      int_en  <= 1'b0;
      ced_off <= 1'b0;
    end else if (wr_ctrl) begin
      gen_en <= bus_wdata[B_EN];
      int_en <= bus_wdata[B_IE];
      if (!gen_en) ced_off <= bus_wdata[B_CED];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q <= '0;
      ready <= 1'b0;
    end else if (core_valid) begin
      buf_q <= core_word;
      ready <= 1'b1;
    end else if (rd_data) begin
      ready <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clk_live  <= 1'b0;
      seed_live <= 1'b0;
      clk_stky  <= 1'b0;
      seed_stky <= 1'b0;
    end else begin
      clk_live  <= clk_err_now;
      seed_live <= core_seed_err;
      if (clk_err_now) clk_stky <= 1'b1;
      else if (wr_stat && !bus_wdata[B_CLKS]) clk_stky <= 1'b0;
      if (core_seed_err) seed_stky <= 1'b1;
      else if (wr_stat && !bus_wdata[B_SEDS]) seed_stky <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_CTRL: begin
        bus_rdata[B_EN]  = gen_en;
        bus_rdata[B_IE]  = int_en;
        bus_rdata[B_CED] = ced_off;
      end
      OFF_STAT: begin
        bus_rdata[B_RDY]  = ready;
        bus_rdata[B_CLKL] = clk_live;
        bus_rdata[B_SEDL] = seed_live;
        bus_rdata[B_CLKS] = clk_stky;
        bus_rdata[B_SEDS] = seed_stky;
      end
      OFF_DATA: bus_rdata = buf_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign core_en     = gen_en;
  assign core_ced_en = gen_en && !ced_off;
  assign irq         = int_en && (ready || clk_stky || seed_stky);

  a_r3_ced_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && gen_en) |=> $stable(ced_off));
  a_r4_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid |=> ready);
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !core_valid) |=> !ready);
  a_r7_clk_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_stky && !wr_stat) |=> clk_stky);
  a_r7_seed_sticky_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (seed_stky && !wr_stat) |=> seed_stky);
  a_r7_seed_with_live: assert property (@(posedge clk) disable iff (!rst_n)
    seed_live |-> seed_stky || $past(wr_stat));
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !irq);
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != OFF_CTRL && bus_addr != OFF_STAT && bus_addr != OFF_DATA) |-> bus_rdata == '0);

endmodule

// File: tb/test_rng_regfile.sv
`timescale 1ns/1ps
module test_rng_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [31:0] core_word = '0;
  logic        core_valid = 1'b0, core_clk_err = 1'b0, core_seed_err = 1'b0;
  logic        core_en, core_ced_en, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rng_regfile i_rng_regfile (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .core_word(core_word), .core_valid(core_valid), .core_clk_err(core_clk_err),
    .core_seed_err(core_seed_err), .core_en(core_en), .core_ced_en(core_ced_en),
    .irq(irq));

  // {write, req number, offset, data}: write=1 writes data, write=0 expects data on a read
  localparam logic [50:0] VEC [14] = '{
    {1'b1, 8'd2,  10'h000, 32'hFFFF_FFFF},
    {1'b0, 8'd2,  10'h000, 32'h0000_002C},  // R2 only mapped bits
    {1'b1, 8'd3,  10'h000, 32'h0000_0004},
    {1'b0, 8'd3,  10'h000, 32'h0000_0024},  // R3 bit5 locked, was enabled
    {1'b1, 8'd3,  10'h000, 32'h0000_0000},
    {1'b0, 8'd3,  10'h000, 32'h0000_0020},  // R3 still locked
    {1'b1, 8'd3,  10'h000, 32'h0000_0000},
    {1'b0, 8'd3,  10'h000, 32'h0000_0000},  // R3 unlocked now
    {1'b1, 8'd8,  10'h004, 32'hFFFF_FFFF},
    {1'b0, 8'd8,  10'h004, 32'h0000_0000},  // R8 status write ignored
    {1'b1, 8'd8,  10'h008, 32'hDEAD_BEEF},
    {1'b0, 8'd8,  10'h008, 32'h0000_0000},  // R8 data write ignored
    {1'b0, 8'd10, 10'h00C, 32'h0000_0000},  // R10
    {1'b0, 8'd10, 10'h3FC, 32'h0000_0000}   // R10
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [9:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(bus_rdata, exp, req);
  endtask

  task automatic pulse_word(input logic [31:0] w);
    @(negedge clk);
    core_word = w; core_valid = 1'b1;
    @(negedge clk);
    core_valid = 1'b0;
  endtask

  task automatic read_data;
    @(negedge clk);
    bus_addr = 10'h008; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    peek(10'h000, 32'h0, "R1 ctrl");
    peek(10'h004, 32'h0, "R1 status");
    peek(10'h008, 32'h0, "R1 data");
    chk({29'd0, irq, core_en, core_ced_en}, 32'h0, "R1 outputs");

    for (int i = 0; i < 14; i++) begin
      if (VEC[i][50]) wr(VEC[i][41:32], VEC[i][31:0]);
      else begin
        @(negedge clk);
        peek(VEC[i][41:32], VEC[i][31:0], $sformatf("R%0d vector %0d", VEC[i][49:42], i));
      end
    end

    // R2 enable outputs, R3 lock while running
    wr(10'h000, 32'h4);
    chk({30'd0, core_en, core_ced_en}, 32'h3, "R2 enable outputs");
    wr(10'h000, 32'h24);
    chk({30'd0, core_en, core_ced_en}, 32'h3, "R3 clock check kept on");

    // R4 word load, R9 irq
    pulse_word(32'hA5A5_0001);
    peek(10'h004, 32'h1, "R4 ready");
    peek(10'h008, 32'hA5A5_0001, "R4 data");
    chk({31'd0, irq}, 32'h0, "R9 irq masked");
    wr(10'h000, 32'h0C);
    chk({31'd0, irq}, 32'h1, "R9 irq on ready");

    // R5 read clears; collision keeps ready
    read_data;
    peek(10'h004, 32'h0, "R5 ready cleared");
    chk({31'd0, irq}, 32'h0, "R9 irq drops");
    pulse_word(32'h1234_5678);
    @(negedge clk);
    bus_addr = 10'h008; bus_rd = 1'b1; core_word = 32'h0BAD_F00D; core_valid = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0; core_valid = 1'b0;
    peek(10'h004, 32'h1, "R5 collision ready kept");
    peek(10'h008, 32'h0BAD_F00D, "R5 collision new word");
    read_data;

    // R4 accepted while disabled, core_en low
    wr(10'h000, 32'h0);
    pulse_word(32'hCAFE_0002);
    peek(10'h004, 32'h1, "R4 ready while disabled");
    chk({31'd0, core_en}, 32'h0, "R4 core_en low");
    read_data;

    // R6/R7 seed fault
    wr(10'h000, 32'h08);
    @(negedge clk); core_seed_err = 1'b1;
    @(negedge clk); core_seed_err = 1'b0;
    peek(10'h004, 32'h44, "R6 R7 seed live and sticky");
    chk({31'd0, irq}, 32'h1, "R9 irq on seed");
    @(negedge clk);
    peek(10'h004, 32'h40, "R7 seed sticky after live drops");
    wr(10'h004, 32'hFFFF_FFFF);
    peek(10'h004, 32'h40, "R7 write one no effect");
    wr(10'h004, 32'h0);
    peek(10'h004, 32'h00, "R7 write zero clears");
    chk({31'd0, irq}, 32'h0, "R9 irq off after clear");

    // R7 set beats clear
    @(negedge clk);
    core_seed_err = 1'b1; bus_addr = 10'h004; bus_wdata = 32'h0; bus_wr = 1'b1;
    @(negedge clk);
    core_seed_err = 1'b0; bus_wr = 1'b0;
    peek(10'h004, 32'h44, "R7 set wins over clear");
    wr(10'h004, 32'h0);

    // R6/R7 clock fault, then masked
    @(negedge clk); core_clk_err = 1'b1;
    @(negedge clk); core_clk_err = 1'b0;
    peek(10'h004, 32'h22, "R6 R7 clock live and sticky");
    wr(10'h004, 32'h0);
    wr(10'h000, 32'h20);
    chk({31'd0, core_ced_en}, 32'h0, "R2 clock check disabled");
    @(negedge clk); core_clk_err = 1'b1;
    @(negedge clk); core_clk_err = 1'b0;
    peek(10'h004, 32'h0, "R6 clock fault masked");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule